// File: doc/BRIEF.md
# Software-Assisted Cut-Through DMA Controller

This block lets software attach a DMA descriptor of its own to a received packet, whether that packet has already been fully reassembled or is still arriving. Software first writes the descriptor address into an arming register. Then it writes the packet base address into an operation register. The block asks the reassembly logic for the live state of that packet and takes one of three actions:

- it issues a DMA request at once (packet complete and clean);
- it posts a canceled event carrying the descriptor address (packet complete with errors);
- it records the descriptor in a per-context pending table (packet still in progress).

A recorded entry is resolved later, when the reassembly logic reports that the packet of that context has completed or failed. The block never frees packet buffers. The DMA engine and the event queue sit outside it and take one-cycle request pulses.

The control state machine has three states.

- **ST_IDLE** waits for an accepted operation write. The move idle→lookup happens when the arming register holds a fresh descriptor.
- **ST_LOOKUP** holds the lookup request until the reassembly logic acknowledges it. There are two exits:
  - lookup→idle, when the packet is still in progress: the pending entry is marked.
  - lookup→issue, when the packet is finished, or when a completion for the same context arrives in the acknowledge cycle.
- **ST_ISSUE** emits the immediate request. The move issue→idle happens in any cycle where no deferred resolution claims the output. Otherwise the block stays in issue for that cycle.

Top module: `ct_cutthru_dma`

## Requirements
- R1: After reset, dma_valid, evt_valid, lkp_req and err_flag are 0 and no context is pending. A completion pulse on any context then produces no output.
- R2: An operation write (reg_sel=1) with no descriptor write (reg_sel=0) since the last accepted operation is ignored. In that case no lookup starts, no output appears, and err_flag becomes 1 and stays 1 until reset.
- R3: An operation write while an earlier operation is still in lookup or issue is ignored. It does not change lkp_base, it produces no extra output, and it sets err_flag.
- R4: When the lookup returns status 2'b01 (complete, no errors), dma_valid pulses for one cycle, two clock edges after the edge that sampled the operation write. The pulse carries these fields:
  - dma_desc: the descriptor word, unchanged, including its low-order count bits;
  - dma_ctx: the looked-up context;
  - dma_hdr_ptr: the base address plus 20, which is the sixth 32-bit header word and holds the packet data address.
- R5: When the lookup returns status 2'b10 or 2'b11 (complete, with errors), evt_valid pulses at that same cycle instead. evt_desc holds the descriptor address and evt_ctx holds the context. No DMA request is issued.
- R6: When the lookup returns status 2'b00 (in progress), no output appears and the context is marked pending. A later completion pulse for that context with cmp_err=0 gives a dma_valid pulse with the stored descriptor and header pointer. The pulse appears right after the clock edge that sampled the completion.
- R7: A completion pulse with cmp_err=1 on a pending context gives an evt_valid pulse with the stored descriptor, at the same timing as R6.
- R8: A pending entry is cleared when its deferred action is issued. A completion pulse on a context that is not pending produces no output.
- R9: When a deferred resolution and an immediate issue are ready in the same cycle, the deferred one is output first and the immediate one one cycle later. dma_valid and evt_valid are never both 1.
- R10: Suppose a completion pulse for the looked-up context arrives in the cycle the lookup is acknowledged with status 2'b00. The operation is then resolved immediately, as R4 (cmp_err=0) or R5 (cmp_err=1), and the context is not marked.
- R11: lkp_req stays 1 with lkp_base equal to the operation's base address until lkp_ack is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: descriptor-address register, 1: operation register |
| reg_wr_data | input | AW | Write data (descriptor word or packet base address) |
| lkp_req | output | 1 | Packet-state lookup request |
| lkp_base | output | AW | Packet base address being looked up |
| lkp_ack | input | 1 | Lookup answer valid |
| lkp_ctx | input | CW | Channel context owning the packet |
| lkp_status | input | 2 | 00 in progress, 01 complete clean, 1x complete with errors |
| cmp_valid | input | 1 | Reassembly completion or failure pulse |
| cmp_ctx | input | CW | Context of the completion |
| cmp_err | input | 1 | Completion had errors |
| dma_valid | output | 1 | DMA request pulse |
| dma_desc | output | AW | Descriptor word for the DMA engine |
| dma_hdr_ptr | output | AW | Address of the header word holding the data address |
| dma_ctx | output | CW | Context of the DMA request |
| evt_valid | output | 1 | Canceled-event pulse |
| evt_desc | output | AW | Descriptor address that would have been used |
| evt_ctx | output | CW | Context of the canceled event |
| err_flag | output | 1 | Sticky ignored-operation flag |

## Verification
A corrupted pending bit or stored descriptor stays hidden until that context next completes. It then shows up on the same edge that samples the completion, either as a missing pulse or as one carrying the wrong descriptor. This is why every context is marked and then resolved, and then resolved a second time, which must produce nothing. A stuck state register shows up at the ports one or two cycles after an operation write, as a held lkp_req, a late pulse or a missing pulse. The bench therefore checks the exact cycle of every pulse against the sampling edge of the write or completion that caused it.

// File: rtl/ct_pkg.sv
package ct_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_ISSUE  = 2'd2
    } ct_state_e;

    localparam logic [1:0] STAT_BUSY = 2'b00;
    localparam int HDR_WORD_IDX = 5;
    localparam int WORD_BYTES   = 4;
endpackage

// File: rtl/ct_arm_reg.sv
module ct_arm_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_desc,
    input  logic [AW-1:0] wr_data,
    input  logic          consume,
    output logic          armed,
    output logic [AW-1:0] desc
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            desc  <= '0;
        end else if (wr_desc) begin
            armed <= 1'b1;
            desc  <= wr_data;
        end else if (consume) begin
            armed <= 1'b0;
        end
    end
endmodule

// File: rtl/ct_pend_table.sv
module ct_pend_table #(
    parameter int AW   = 32,
    parameter int NCTX = 8,
    localparam int CW  = $clog2(NCTX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mark,
    input  logic [CW-1:0] mark_ctx,
    input  logic [AW-1:0] mark_desc,
    input  logic [AW-1:0] mark_base,
    input  logic          cmp_valid,
    input  logic [CW-1:0] cmp_ctx,
    output logic          hit,
    output logic [AW-1:0] hit_desc,
    output logic [AW-1:0] hit_base,
    output logic [NCTX-1:0] pend_bits
);
    logic [NCTX-1:0] pend_q;
    logic [AW-1:0]   desc_mem [NCTX];
    logic [AW-1:0]   base_mem [NCTX];

    assign hit       = cmp_valid && pend_q[cmp_ctx];
    assign hit_desc  = desc_mem[cmp_ctx];
    assign hit_base  = base_mem[cmp_ctx];
    assign pend_bits = pend_q;

    for (genvar i = 0; i < NCTX; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
            end else if (hit && cmp_ctx == CW'(i)) begin
                pend_q[i] <= 1'b0;
            end else if (mark && mark_ctx == CW'(i)) begin
                pend_q[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (mark && mark_ctx == CW'(i)) begin
                desc_mem[i] <= mark_desc;
                base_mem[i] <= mark_base;
            end
        end
    end
endmodule

// File: rtl/ct_ctrl.sv
module ct_ctrl
    import ct_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_wr,
    input  logic [AW-1:0] op_base,
    input  logic          armed,
    input  logic [AW-1:0] arm_desc,
    output logic          consume,
    output logic          lkp_req,
    output logic [AW-1:0] lkp_base,
    input  logic          lkp_ack,
    input  logic [CW-1:0] lkp_ctx,
    input  logic [1:0]    lkp_status,
    input  logic          cmp_valid,
    input  logic [CW-1:0] cmp_ctx,
    input  logic          cmp_err,
    input  logic          hit,
    input  logic [AW-1:0] hit_desc,
    input  logic [AW-1:0] hit_base,
    output logic          mark,
    output logic [CW-1:0] mark_ctx,
    output logic [AW-1:0] mark_desc,
    output logic [AW-1:0] mark_base,
    output logic          dma_valid,
    output logic [AW-1:0] dma_desc,
    output logic [AW-1:0] dma_hdr_ptr,
    output logic [CW-1:0] dma_ctx,
    output logic          evt_valid,
    output logic [AW-1:0] evt_desc,
    output logic [CW-1:0] evt_ctx,
    output logic          err_flag,
    output ct_state_e     state
);
    localparam logic [AW-1:0] HDR_OFS = AW'(HDR_WORD_IDX * WORD_BYTES);

    ct_state_e     state_q, state_d;
    logic [AW-1:0] base_q, desc_q;
    logic [CW-1:0] ctx_q;
    logic          cancel_q;
    logic          accept, race, pkt_busy;

    assign accept   = op_wr && armed && (state_q == ST_IDLE);
    assign race     = cmp_valid && (cmp_ctx == lkp_ctx);
    assign pkt_busy = (lkp_status == STAT_BUSY);

    assign consume   = accept;
    assign lkp_req   = (state_q == ST_LOOKUP);
    assign lkp_base  = base_q;
    assign mark      = (state_q == ST_LOOKUP) && lkp_ack && pkt_busy && !race;
    assign mark_ctx  = lkp_ctx;
    assign mark_desc = desc_q;
    assign mark_base = base_q;
    assign state     = state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_LOOKUP;
            ST_LOOKUP: if (lkp_ack) state_d = (pkt_busy && !race) ? ST_IDLE : ST_ISSUE;
            ST_ISSUE:  if (!hit) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            desc_q   <= '0;
            ctx_q    <= '0;
            cancel_q <= 1'b0;
        end else begin
            if (accept) begin
                base_q <= op_base;
                desc_q <= arm_desc;
            end
            if (state_q == ST_LOOKUP && lkp_ack) begin
                ctx_q    <= lkp_ctx;
                cancel_q <= pkt_busy ? cmp_err : lkp_status[1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_valid   <= 1'b0;
            dma_desc    <= '0;
            dma_hdr_ptr <= '0;
            dma_ctx     <= '0;
            evt_valid   <= 1'b0;
            evt_desc    <= '0;
            evt_ctx     <= '0;
        end else begin
            dma_valid <= 1'b0;
            evt_valid <= 1'b0;
            if (hit) begin
                if (cmp_err) begin
                    evt_valid <= 1'b1;
                    evt_desc  <= hit_desc;
                    evt_ctx   <= cmp_ctx;
                end else begin
                    dma_valid   <= 1'b1;
                    dma_desc    <= hit_desc;
                    dma_hdr_ptr <= hit_base + HDR_OFS;
                    dma_ctx     <= cmp_ctx;
                end
            end else if (state_q == ST_ISSUE) begin
                if (cancel_q) begin
                    evt_valid <= 1'b1;
                    evt_desc  <= desc_q;
                    evt_ctx   <= ctx_q;
                end else begin
                    dma_valid   <= 1'b1;
                    dma_desc    <= desc_q;
                    dma_hdr_ptr <= base_q + HDR_OFS;
                    dma_ctx     <= ctx_q;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                         err_flag <= 1'b0;
        else if (op_wr && (!armed || state_q != ST_IDLE))   err_flag <= 1'b1;
    end
endmodule

// File: rtl/ct_cutthru_dma.sv
module ct_cutthru_dma
    import ct_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NCTX = 8,
    localparam int CW  = $clog2(NCTX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic          reg_sel,
    input  logic [AW-1:0] reg_wr_data,
    output logic          lkp_req,
    output logic [AW-1:0] lkp_base,
    input  logic          lkp_ack,
    input  logic [CW-1:0] lkp_ctx,
    input  logic [1:0]    lkp_status,
    input  logic          cmp_valid,
    input  logic [CW-1:0] cmp_ctx,
    input  logic          cmp_err,
    output logic          dma_valid,
    output logic [AW-1:0] dma_desc,
    output logic [AW-1:0] dma_hdr_ptr,
    output logic [CW-1:0] dma_ctx,
    output logic          evt_valid,
    output logic [AW-1:0] evt_desc,
    output logic [CW-1:0] evt_ctx,
    output logic          err_flag
);
    logic            op_wr, desc_wr, consume, armed;
    logic [AW-1:0]   arm_desc;
    logic            mark, hit;
    logic [CW-1:0]   mark_ctx;
    logic [AW-1:0]   mark_desc, mark_base, hit_desc, hit_base;
    logic [NCTX-1:0] pend_bits;
    ct_state_e       ctrl_state;

    assign op_wr   = reg_wr_en && reg_sel;
    assign desc_wr = reg_wr_en && !reg_sel;

    ct_arm_reg #(.AW(AW)) u_arm (
        .clk(clk), .rst_n(rst_n), .wr_desc(desc_wr), .wr_data(reg_wr_data),
        .consume(consume), .armed(armed), .desc(arm_desc)
    );

    ct_pend_table #(.AW(AW), .NCTX(NCTX)) u_pend (
        .clk(clk), .rst_n(rst_n), .mark(mark), .mark_ctx(mark_ctx),
        .mark_desc(mark_desc), .mark_base(mark_base), .cmp_valid(cmp_valid),
        .cmp_ctx(cmp_ctx), .hit(hit), .hit_desc(hit_desc), .hit_base(hit_base),
        .pend_bits(pend_bits)
    );

    ct_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_base(reg_wr_data),
        .armed(armed), .arm_desc(arm_desc), .consume(consume),
        .lkp_req(lkp_req), .lkp_base(lkp_base), .lkp_ack(lkp_ack),
        .lkp_ctx(lkp_ctx), .lkp_status(lkp_status), .cmp_valid(cmp_valid),
        .cmp_ctx(cmp_ctx), .cmp_err(cmp_err), .hit(hit), .hit_desc(hit_desc),
        .hit_base(hit_base), .mark(mark), .mark_ctx(mark_ctx),
        .mark_desc(mark_desc), .mark_base(mark_base), .dma_valid(dma_valid),
        .dma_desc(dma_desc), .dma_hdr_ptr(dma_hdr_ptr), .dma_ctx(dma_ctx),
        .evt_valid(evt_valid), .evt_desc(evt_desc), .evt_ctx(evt_ctx),
        .err_flag(err_flag), .state(ctrl_state)
    );
endmodule

// File: rtl/ct_dma_chk.sv
module ct_dma_chk
    import ct_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NCTX = 8,
    localparam int CW  = $clog2(NCTX)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_wr,
    input logic            armed,
    input ct_state_e       state,
    input logic            lkp_req,
    input logic [AW-1:0]   lkp_base,
    input logic            lkp_ack,
    input logic            cmp_valid,
    input logic [CW-1:0]   cmp_ctx,
    input logic [NCTX-1:0] pend_bits,
    input logic            dma_valid,
    input logic            evt_valid,
    input logic            err_flag
);
    p_excl_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_valid && evt_valid));

    p_lkp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_req && !lkp_ack |=> lkp_req && $stable(lkp_base));

    p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_noarm_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr && !armed |=> err_flag);

    p_busy_op_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr && state != ST_IDLE |=> err_flag);

    p_defer_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && pend_bits[cmp_ctx] |=> dma_valid || evt_valid);

    p_defer_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && pend_bits[cmp_ctx] |=> !pend_bits[$past(cmp_ctx)]);

    p_issue_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ISSUE && !(cmp_valid && pend_bits[cmp_ctx]) |=> dma_valid || evt_valid);
endmodule

bind ct_cutthru_dma ct_dma_chk #(.AW(AW), .NCTX(NCTX)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .armed(armed), .state(ctrl_state),
    .lkp_req(lkp_req), .lkp_base(lkp_base), .lkp_ack(lkp_ack),
    .cmp_valid(cmp_valid), .cmp_ctx(cmp_ctx), .pend_bits(pend_bits),
    .dma_valid(dma_valid), .evt_valid(evt_valid), .err_flag(err_flag)
);

// File: tb/ct_cutthru_dma_tb_top.sv
module ct_cutthru_dma_tb_top;
    localparam int AW = 32;
    localparam int NCTX = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0, reg_sel = 1'b0;
    logic [AW-1:0] reg_wr_data = '0;
    logic lkp_req, lkp_ack = 1'b1;
    logic [AW-1:0] lkp_base;
    logic [2:0] lkp_ctx = '0;
    logic [1:0] lkp_status = 2'b01;
    logic cmp_valid = 1'b0, cmp_err = 1'b0;
    logic [2:0] cmp_ctx = '0;
    logic dma_valid, evt_valid, err_flag;
    logic [AW-1:0] dma_desc, dma_hdr_ptr, evt_desc;
    logic [2:0] dma_ctx, evt_ctx;

    always #5 clk = ~clk;

    ct_cutthru_dma #(.AW(AW), .NCTX(NCTX)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wr_data(reg_wr_data), .lkp_req(lkp_req), .lkp_base(lkp_base),
        .lkp_ack(lkp_ack), .lkp_ctx(lkp_ctx), .lkp_status(lkp_status),
        .cmp_valid(cmp_valid), .cmp_ctx(cmp_ctx), .cmp_err(cmp_err),
        .dma_valid(dma_valid), .dma_desc(dma_desc), .dma_hdr_ptr(dma_hdr_ptr),
        .dma_ctx(dma_ctx), .evt_valid(evt_valid), .evt_desc(evt_desc),
        .evt_ctx(evt_ctx), .err_flag(err_flag)
    );

    int cyc = 0;
    int checks = 0, errors = 0;
    bit done = 0;
    int dma_n = 0, evt_n = 0;
    logic [AW-1:0] dl_desc [256];
    logic [AW-1:0] dl_ptr  [256];
    logic [2:0]    dl_ctx  [256];
    int            dl_cyc  [256];
    logic [AW-1:0] el_desc [256];
    logic [2:0]    el_ctx  [256];
    int            el_cyc  [256];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (dma_valid) begin
            dl_desc[dma_n[7:0]] = dma_desc;
            dl_ptr[dma_n[7:0]]  = dma_hdr_ptr;
            dl_ctx[dma_n[7:0]]  = dma_ctx;
            dl_cyc[dma_n[7:0]]  = cyc;
            dma_n = dma_n + 1;
        end
        if (evt_valid) begin
            el_desc[evt_n[7:0]] = evt_desc;
            el_ctx[evt_n[7:0]]  = evt_ctx;
            el_cyc[evt_n[7:0]]  = cyc;
            evt_n = evt_n + 1;
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic reg_write(input logic sel, input logic [AW-1:0] d);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wr_data = d;
        tick(1);
        reg_wr_en = 1'b0; reg_sel = 1'b0; reg_wr_data = '0;
    endtask

    task automatic cmp_pulse(input logic [2:0] c, input logic e);
        cmp_valid = 1'b1; cmp_ctx = c; cmp_err = e;
        tick(1);
        cmp_valid = 1'b0; cmp_err = 1'b0;
    endtask

    function automatic logic [AW-1:0] desc_of(input int c, input int s);
        return 32'h4000_0000 | AW'(c << 12) | AW'(s << 8) | AW'(c & 3);
    endfunction

    function automatic logic [AW-1:0] base_of(input int c, input int s);
        return 32'h8000_0000 + AW'(c << 16) + AW'(s << 10);
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int d0, e0, opc, cc;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 dma_valid", dma_valid, 0);
        check("R1 evt_valid", evt_valid, 0);
        check("R1 lkp_req", lkp_req, 0);
        check("R1 err_flag", err_flag, 0);
        for (int c = 0; c < NCTX; c++) cmp_pulse(3'(c), 1'b0);
        tick(2);
        check("R1 no output from idle completions", dma_n + evt_n, 0);

        // R4 / R5 sweep of contexts and finished statuses
        for (int c = 0; c < NCTX; c++) begin
            for (int s = 1; s < 4; s++) begin
                d0 = dma_n; e0 = evt_n;
                lkp_ctx = 3'(c); lkp_status = 2'(s);
                reg_write(1'b0, desc_of(c, s));
                reg_write(1'b1, base_of(c, s));
                opc = cyc;
                tick(4);
                if (s == 1) begin
                    check("R4 dma count", dma_n, d0 + 1);
                    check("R4 evt count", evt_n, e0);
                    check("R4 desc", dl_desc[d0[7:0]], desc_of(c, s));
                    check("R4 hdr ptr", dl_ptr[d0[7:0]], base_of(c, s) + 20);
                    check("R4 ctx", dl_ctx[d0[7:0]], c);
                    check("R4 cycle", dl_cyc[d0[7:0]], opc + 2);
                end else begin
                    check("R5 evt count", evt_n, e0 + 1);
                    check("R5 dma count", dma_n, d0);
                    check("R5 desc", el_desc[e0[7:0]], desc_of(c, s));
                    check("R5 ctx", el_ctx[e0[7:0]], c);
                    check("R5 cycle", el_cyc[e0[7:0]], opc + 2);
                end
            end
        end

        // R6 mark every context while in progress
        lkp_status = 2'b00;
        for (int c = 0; c < NCTX; c++) begin
            d0 = dma_n; e0 = evt_n;
            lkp_ctx = 3'(c);
            reg_write(1'b0, desc_of(c, 0));
            reg_write(1'b1, base_of(c, 0));
            tick(4);
            check("R6 no output while in progress", dma_n + evt_n, d0 + e0);
        end
        // R6 / R7 resolve: even contexts clean, odd contexts failed
        for (int c = 0; c < NCTX; c++) begin
            d0 = dma_n; e0 = evt_n;
            cmp_pulse(3'(c), 1'(c & 1));
            cc = cyc;
            tick(2);
            if ((c & 1) == 0) begin
                check("R6 deferred dma count", dma_n, d0 + 1);
                check("R6 deferred desc", dl_desc[d0[7:0]], desc_of(c, 0));
                check("R6 deferred hdr ptr", dl_ptr[d0[7:0]], base_of(c, 0) + 20);
                check("R6 deferred ctx", dl_ctx[d0[7:0]], c);
                check("R6 deferred cycle", dl_cyc[d0[7:0]], cc);
            end else begin
                check("R7 deferred evt count", evt_n, e0 + 1);
                check("R7 deferred desc", el_desc[e0[7:0]], desc_of(c, 0));
                check("R7 deferred ctx", el_ctx[e0[7:0]], c);
                check("R7 deferred cycle", el_cyc[e0[7:0]], cc);
            end
        end
        // R8 entries cleared
        d0 = dma_n; e0 = evt_n;
        for (int c = 0; c < NCTX; c++) cmp_pulse(3'(c), 1'b0);
        tick(2);
        check("R8 no output after clear", dma_n + evt_n, d0 + e0);

        // R9 deferred wins over immediate in the same cycle
        lkp_ctx = 3'd3; lkp_status = 2'b00;
        reg_write(1'b0, desc_of(3, 0));
        reg_write(1'b1, base_of(3, 0));
        tick(3);
        d0 = dma_n;
        lkp_ctx = 3'd5; lkp_status = 2'b01;
        reg_write(1'b0, desc_of(5, 1));
        reg_write(1'b1, base_of(5, 1));
        opc = cyc;
        tick(1);
        cmp_pulse(3'd3, 1'b0);
        tick(3);
        check("R9 dma count", dma_n, d0 + 2);
        check("R9 first is deferred", dl_ctx[d0[7:0]], 3);
        check("R9 deferred cycle", dl_cyc[d0[7:0]], opc + 2);
        check("R9 second is immediate", dl_ctx[(d0 + 1) & 255], 5);
        check("R9 immediate cycle", dl_cyc[(d0 + 1) & 255], opc + 3);

        // R10 completion racing the lookup answer
        e0 = evt_n; d0 = dma_n;
        lkp_ctx = 3'd6; lkp_status = 2'b00;
        reg_write(1'b0, desc_of(6, 2));
        reg_write(1'b1, base_of(6, 2));
        opc = cyc;
        cmp_pulse(3'd6, 1'b1);
        tick(3);
        check("R10 race evt count", evt_n, e0 + 1);
        check("R10 race desc", el_desc[e0[7:0]], desc_of(6, 2));
        check("R10 race cycle", el_cyc[e0[7:0]], opc + 2);
        cmp_pulse(3'd6, 1'b0);
        tick(2);
        check("R10 context not marked", dma_n, d0);

        // R2 operation without a fresh descriptor
        d0 = dma_n; e0 = evt_n;
        lkp_status = 2'b01;
        check("R2 err before", err_flag, 0);
        reg_write(1'b1, base_of(1, 1));
        check("R2 no lookup", lkp_req, 0);
        tick(3);
        check("R2 no output", dma_n + evt_n, d0 + e0);
        check("R2 err set", err_flag, 1);
        tick(5);
        check("R2 err sticky", err_flag, 1);

        // R11 lookup held; R3 op write while busy ignored
        lkp_ack = 1'b0; lkp_ctx = 3'd2; lkp_status = 2'b01;
        reg_write(1'b0, desc_of(2, 1));
        reg_write(1'b1, base_of(2, 1));
        for (int k = 0; k < 4; k++) begin
            check("R11 lkp_req held", lkp_req, 1);
            check("R11 lkp_base held", lkp_base, base_of(2, 1));
            tick(1);
        end
        reg_write(1'b0, desc_of(7, 1));
        reg_write(1'b1, base_of(7, 1));
        check("R3 lkp_base unchanged", lkp_base, base_of(2, 1));
        check("R3 err set", err_flag, 1);
        d0 = dma_n;
        lkp_ack = 1'b1;
        tick(4);
        check("R3 single output", dma_n, d0 + 1);
        check("R11 desc after held lookup", dl_desc[d0[7:0]], desc_of(2, 1));
        check("R3 no second lookup", lkp_req, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule